// File: doc/BRIEF.md
# Word Shift Execution Unit

This unit evaluates the four word-sized shift operations of a core whose register file is twice the word width: logical left, logical right, algebraic right with the count taken from a register, and algebraic right with the count taken from an immediate field. It accepts the source register value, the count register value, the immediate count, the extended opcode, the record flag and the summary-overflow flag. It returns the full-width destination value, the carry flag with its write enable, and a four-bit condition field with its write enable.

The register-count forms look only at the lowest `log2(WLEN)+1` bits of the count register. The top bit of that masked count selects the saturated case: zero for the logical forms and a word of sign copies for the algebraic forms. Logical results are zero-extended into the destination and algebraic results are sign-extended into it. All outputs are registered, so a result appears one clock after its operands.

Top module: `wsh_unit`

## Requirements
- R1: Register-count forms use only the lowest CNTW = log2(WLEN)+1 bits of the count register. All higher bits are ignored, so a count register value of 2·WLEN acts as a shift of 0.
- R2: For the logical forms, a masked count of WLEN or more gives a zero result. A smaller count shifts the low WLEN bits of the source by that amount.
- R3: Logical results are zero-extended. Destination bits XLEN-1..WLEN are 0.
- R4: Algebraic results are sign-extended. Destination bits XLEN-1..WLEN equal result bit WLEN-1. For example, with WLEN=32, 0x80000000 shifted right by 1 gives 0xFFFFFFFF_C0000000.
- R5: For the algebraic register form with a masked count of WLEN or more, the low word is WLEN copies of source bit WLEN-1, and the carry equals that bit.
- R6: The algebraic carry is 1 only when the source word is negative and at least one 1 bit is shifted out. A count of 0 leaves the word unchanged and gives a carry of 0. The carry write enable is 1 for both algebraic forms and 0 for the logical forms.
- R7: The immediate algebraic form takes its count (0..WLEN-1) from the SH field input and ignores the count register.
- R8: When the record flag is set, the condition field is written. Its layout is {LT,GT,EQ,SO} in bits 3..0. LT, GT and EQ come from the signed WLEN-bit view of the result, so a result with bit WLEN-1 set reports LT. SO is a copy of the summary-overflow input. When the record flag is clear, the condition write enable is 0.
- R9: The operation is selected by the 10-bit extended opcode: 24 is logical left, 536 is logical right, 792 is algebraic right by register, and 824 is algebraic right by immediate.
- R10: Any other extended opcode gives a zero destination, a zero carry and condition field, and clears both write enables.
- R11: Outputs are registered with one cycle of latency. While reset is active, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rs_i | input | XLEN | Source register value |
| rb_i | input | XLEN | Count register value |
| sh_i | input | log2(WLEN) | Immediate count field |
| xo_i | input | 10 | Extended opcode |
| rc_i | input | 1 | Record flag |
| xer_so_i | input | 1 | Summary-overflow flag |
| rd_o | output | XLEN | Destination value |
| ca_o | output | 1 | Carry result |
| ca_we_o | output | 1 | Carry write enable |
| cr0_o | output | 4 | Condition field {LT,GT,EQ,SO} |
| cr0_we_o | output | 1 | Condition field write enable |

## Verification
The bench builds the unit with WLEN=8 and XLEN=16, which gives a 4-bit masked count. With this configuration, every source byte can be combined with every masked count for each register-count form, and with every immediate count for the immediate form. The count register's upper byte is filled with a varying pattern, which exercises the masking on every vector. Expected results are computed with integer arithmetic: multiply or divide by a power of two, with a floored division for the algebraic forms. This covers the saturated counts, the carry on lost bits, and the sign extension at every possible count.

// File: rtl/wsh_pkg.sv
package wsh_pkg;

    localparam logic [9:0] XO_SLW   = 10'd24;
    localparam logic [9:0] XO_SRW   = 10'd536;
    localparam logic [9:0] XO_SRAW  = 10'd792;
    localparam logic [9:0] XO_SRAWI = 10'd824;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_SLW   = 3'd1,
        OP_SRW   = 3'd2,
        OP_SRAW  = 3'd3,
        OP_SRAWI = 3'd4
    } shop_e;

    function automatic shop_e decode_xo(input logic [9:0] xo);
        shop_e op;
        case (xo)
            XO_SLW:   op = OP_SLW;
            XO_SRW:   op = OP_SRW;
            XO_SRAW:  op = OP_SRAW;
            XO_SRAWI: op = OP_SRAWI;
            default:  op = OP_NONE;
        endcase
        return op;
    endfunction

endpackage

// File: rtl/wsh_count.sv
module wsh_count #(
    parameter int WLEN = 32,
    localparam int SHW  = $clog2(WLEN),
    localparam int CNTW = SHW + 1
) (
    input  logic [CNTW-1:0] rb_low_i,
    input  logic [SHW-1:0]  sh_i,
    input  logic            use_imm_i,
    output logic [CNTW-1:0] cnt_o
);
    always_comb begin
        if (use_imm_i) begin
            cnt_o = {1'b0, sh_i};
        end else begin
            cnt_o = rb_low_i;
        end
    end
endmodule

// File: rtl/wsh_logical.sv
module wsh_logical #(
    parameter int WLEN = 32,
    localparam int SHW  = $clog2(WLEN),
    localparam int CNTW = SHW + 1
) (
    input  logic [WLEN-1:0] word_i,
    input  logic [CNTW-1:0] cnt_i,
    input  logic            left_i,
    output logic [WLEN-1:0] res_o
);
    logic [SHW-1:0] amt;

    always_comb begin
        amt = cnt_i[SHW-1:0];
        if (cnt_i[SHW]) begin
            res_o = '0;
        end else if (left_i) begin
            res_o = word_i << amt;
        end else begin
            res_o = word_i >> amt;
        end
    end
endmodule

// File: rtl/wsh_algebraic.sv
module wsh_algebraic #(
    parameter int WLEN = 32,
    localparam int SHW  = $clog2(WLEN),
    localparam int CNTW = SHW + 1
) (
    input  logic [WLEN-1:0] word_i,
    input  logic [CNTW-1:0] cnt_i,
    output logic [WLEN-1:0] res_o,
    output logic            ca_o
);
    logic [SHW-1:0]  amt;
    logic            sign;
    logic [WLEN-1:0] lost_mask;
    logic            lost_one;

    always_comb begin
        amt  = cnt_i[SHW-1:0];
        sign = word_i[WLEN-1];
        for (int i = 0; i < WLEN; i++) begin
            lost_mask[i] = (i < int'(amt));
        end
        lost_one = |(word_i & lost_mask);
        if (cnt_i[SHW]) begin
            res_o = {WLEN{sign}};
            ca_o  = sign;
        end else begin
            res_o = $signed(word_i) >>> amt;
            ca_o  = sign & lost_one;
        end
    end
endmodule

// File: rtl/wsh_cr0.sv
module wsh_cr0 #(
    parameter int WLEN = 32
) (
    input  logic [WLEN-1:0] res_i,
    input  logic            so_i,
    output logic [3:0]      cr_o
);
    logic lt, eq, gt;

    always_comb begin
        lt   = res_i[WLEN-1];
        eq   = (res_i == '0);
        gt   = ~lt & ~eq;
        cr_o = {lt, gt, eq, so_i};
    end
endmodule

// File: rtl/wsh_unit.sv
module wsh_unit
    import wsh_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int WLEN = 32,
    localparam int SHW  = $clog2(WLEN),
    localparam int CNTW = SHW + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XLEN-1:0] rs_i,
    input  logic [XLEN-1:0] rb_i,
    input  logic [SHW-1:0]  sh_i,
    input  logic [9:0]      xo_i,
    input  logic            rc_i,
    input  logic            xer_so_i,
    output logic [XLEN-1:0] rd_o,
    output logic            ca_o,
    output logic            ca_we_o,
    output logic [3:0]      cr0_o,
    output logic            cr0_we_o
);
    typedef struct packed {
        logic [XLEN-1:0] rd;
        logic            ca;
        logic            ca_we;
        logic [3:0]      cr0;
        logic            cr0_we;
    } out_t;

    out_t out_d, out_q;

    shop_e           op;
    logic            use_imm;
    logic [CNTW-1:0] cnt;
    logic [WLEN-1:0] log_res;
    logic [WLEN-1:0] alg_res;
    logic            alg_ca;
    logic [WLEN-1:0] word_res;
    logic [3:0]      cr_field;
    logic            unused_hi;

    assign unused_hi = ^{rb_i[XLEN-1:CNTW], rs_i[XLEN-1:WLEN]};

    assign op      = decode_xo(xo_i);
    assign use_imm = (op == OP_SRAWI);

    wsh_count #(.WLEN(WLEN)) u_count (
        .rb_low_i  (rb_i[CNTW-1:0]),
        .sh_i      (sh_i),
        .use_imm_i (use_imm),
        .cnt_o     (cnt)
    );

    wsh_logical #(.WLEN(WLEN)) u_logical (
        .word_i (rs_i[WLEN-1:0]),
        .cnt_i  (cnt),
        .left_i (op == OP_SLW),
        .res_o  (log_res)
    );

    wsh_algebraic #(.WLEN(WLEN)) u_algebraic (
        .word_i (rs_i[WLEN-1:0]),
        .cnt_i  (cnt),
        .res_o  (alg_res),
        .ca_o   (alg_ca)
    );

    wsh_cr0 #(.WLEN(WLEN)) u_cr0 (
        .res_i (word_res),
        .so_i  (xer_so_i),
        .cr_o  (cr_field)
    );

    always_comb begin
        out_d    = '0;
        word_res = '0;
        case (op)
            OP_SLW, OP_SRW: begin
                word_res     = log_res;
                out_d.rd     = {{(XLEN-WLEN){1'b0}}, log_res};
                out_d.cr0    = cr_field;
                out_d.cr0_we = rc_i;
            end
            OP_SRAW, OP_SRAWI: begin
                word_res     = alg_res;
                out_d.rd     = {{(XLEN-WLEN){alg_res[WLEN-1]}}, alg_res};
                out_d.ca     = alg_ca;
                out_d.ca_we  = 1'b1;
                out_d.cr0    = cr_field;
                out_d.cr0_we = rc_i;
            end
            default: begin
                out_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign rd_o     = out_q.rd;
    assign ca_o     = out_q.ca;
    assign ca_we_o  = out_q.ca_we;
    assign cr0_o    = out_q.cr0;
    assign cr0_we_o = out_q.cr0_we;

endmodule

// File: rtl/wsh_unit_chk.sv
module wsh_unit_chk #(
    parameter int XLEN = 64,
    parameter int WLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic [9:0]      xo_i,
    input logic            rc_i,
    input logic            xer_so_i,
    input logic [XLEN-1:0] rd_o,
    input logic            ca_o,
    input logic            ca_we_o,
    input logic [3:0]      cr0_o,
    input logic            cr0_we_o
);
    logic was_logical, was_alg, was_other;
    assign was_logical = (xo_i == 10'd24) || (xo_i == 10'd536);
    assign was_alg     = (xo_i == 10'd792) || (xo_i == 10'd824);
    assign was_other   = !was_logical && !was_alg;

    // R3
    a_r3_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(was_logical) |-> (rd_o[XLEN-1:WLEN] == '0));

    // R4
    a_r4_sign_ext: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(was_alg) |-> (rd_o[XLEN-1:WLEN] == {(XLEN-WLEN){rd_o[WLEN-1]}}));

    // R6: a carry only comes from a negative word, and the result keeps that sign
    a_r6_ca_negative: assert property (@(posedge clk) disable iff (!rst_n)
        ca_o |-> (ca_we_o && rd_o[WLEN-1]));

    // R6
    a_r6_ca_we: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (ca_we_o == $past(was_alg)));

    // R8
    a_r8_cr0_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        cr0_we_o |-> ($countones(cr0_o[3:1]) == 1 && cr0_o[3] == rd_o[WLEN-1]));

    // R8
    a_r8_cr0_so: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && cr0_we_o |-> (cr0_o[0] == $past(xer_so_i) && $past(rc_i)));

    // R10
    a_r10_unsupported: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(was_other) |-> (rd_o == '0 && !ca_we_o && !cr0_we_o));
endmodule

bind wsh_unit wsh_unit_chk #(.XLEN(XLEN), .WLEN(WLEN)) u_chk (.*);

// File: tb/sim_wsh_unit.sv
`timescale 1ns/1ps
module sim_wsh_unit;
    localparam int XLEN = 16;
    localparam int WLEN = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [XLEN-1:0] rs_i = '0;
    logic [XLEN-1:0] rb_i = '0;
    logic [2:0]      sh_i = '0;
    logic [9:0]      xo_i = '0;
    logic            rc_i = 1'b0;
    logic            xer_so_i = 1'b0;
    logic [XLEN-1:0] rd_o;
    logic            ca_o, ca_we_o, cr0_we_o;
    logic [3:0]      cr0_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    wsh_unit #(.XLEN(XLEN), .WLEN(WLEN)) u0 (
        .clk(clk), .rst_n(rst_n), .rs_i(rs_i), .rb_i(rb_i), .sh_i(sh_i),
        .xo_i(xo_i), .rc_i(rc_i), .xer_so_i(xer_so_i), .rd_o(rd_o),
        .ca_o(ca_o), .ca_we_o(ca_we_o), .cr0_o(cr0_o), .cr0_we_o(cr0_we_o)
    );

    task automatic check(input string req, input logic [XLEN+6:0] act, input logic [XLEN+6:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // kind: 0 left, 1 right, 2 algebraic reg, 3 algebraic imm
    task automatic run(input int kind, input int w, input int rbv, input int shv,
                       input bit rc, input bit so, input string req);
        int c, p, v, q, res8, res16, ca_e, lt, gt, eq;
        logic [XLEN+6:0] act, exp;
        @(negedge clk);
        rs_i = XLEN'((((w * 37) & 255) << 8) | w);
        rb_i = XLEN'(rbv);
        sh_i = 3'(shv);
        rc_i = rc;
        xer_so_i = so;
        case (kind)
            0: xo_i = 10'd24;
            1: xo_i = 10'd536;
            2: xo_i = 10'd792;
            default: xo_i = 10'd824;
        endcase
        c = (kind == 3) ? shv : (rbv & 15);
        p = 1 << c;
        ca_e = 0;
        if (kind == 0) res8 = (w * p) % 256;
        else if (kind == 1) res8 = w / p;
        else begin
            v = (w >= 128) ? w - 256 : w;
            q = (v >= 0) ? v / p : -((-v + p - 1) / p);
            ca_e = (v < 0 && q * p != v) ? 1 : 0;
            res8 = q & 255;
        end
        if (kind >= 2) res16 = (res8 >= 128) ? res8 | 16'hFF00 : res8;
        else res16 = res8;
        lt = (res8 >= 128) ? 1 : 0;
        eq = (res8 == 0) ? 1 : 0;
        gt = (!lt && !eq) ? 1 : 0;
        exp = {XLEN'(res16), 1'(ca_e), 1'(kind >= 2),
               rc ? {1'(lt), 1'(gt), 1'(eq), so} : 4'b0, rc};
        @(posedge clk);
        #1;
        act = {rd_o, ca_o, ca_we_o, cr0_we_o ? cr0_o : 4'b0, cr0_we_o};
        check(req, act, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R11: outputs zero in reset
        check("R11 reset", {rd_o, ca_o, ca_we_o, cr0_o, cr0_we_o}, '0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: count register value 2*WLEN acts as shift of 0
        run(0, 8'h34, 16, 0, 1, 0, "R1 left count 0x10");
        run(1, 8'hF0, 16'hA048, 0, 0, 0, "R1 right masked 8 gives zero");
        run(1, 8'hF0, 16'h5A14, 0, 0, 0, "R1 right masked 4");
        // R4: 0x80 >> 1 sign-extended
        run(2, 8'h80, 1, 0, 1, 1, "R4 0x80>>1");
        // R7: immediate 7 on 0x80 gives all ones
        run(3, 8'h80, 0, 7, 1, 0, "R7 imm 7 on 0x80");
        // R6: count 0 leaves word, carry 0
        run(2, 8'hFF, 0, 0, 0, 0, "R6 count 0");

        for (int kind = 0; kind < 3; kind++) begin
            for (int w = 0; w < 256; w++) begin
                for (int c = 0; c < 16; c++) begin
                    int rbv;
                    rbv = (((w * 13 + c * 7 + kind) & 255) << 8) | (((w + c) & 1) << 4 & 0) | c;
                    rbv = rbv | ((((w ^ c) & 7)) << 4 & 16'h00E0) ;
                    rbv = (rbv & 16'hFFE0) | c | ((w & 1) ? 0 : 0);
                    if (kind < 2)
                        run(kind, w, rbv, (w + c) & 7, (c & 1) == 1, (w & 1) == 1,
                            c >= 8 ? "R2 logical saturated" : "R3 logical shift");
                    else
                        run(kind, w, rbv, (w + c) & 7, (c & 2) == 2, (w & 2) == 2,
                            c >= 8 ? "R5 algebraic saturated" : "R6 algebraic carry");
                end
            end
        end
        for (int w = 0; w < 256; w++) begin
            for (int s = 0; s < 8; s++) begin
                run(3, w, 16'hFFFF, s, (s & 1) == 1, (w & 4) == 4, "R7 immediate form");
            end
        end

        // R8: record flag clear disables the condition write
        run(2, 8'h80, 1, 0, 0, 1, "R8 rc clear");
        // R9/R10: unsupported extended opcodes
        foreach (rs_i[i]) begin end
        for (int k = 0; k < 4; k++) begin
            logic [9:0] xv;
            xv = (k == 0) ? 10'd0 : (k == 1) ? 10'd25 : (k == 2) ? 10'd794 : 10'd1023;
            @(negedge clk);
            xo_i = xv;
            rs_i = 16'hFF80;
            rb_i = 16'h0001;
            rc_i = 1'b1;
            xer_so_i = 1'b1;
            @(posedge clk);
            #1;
            check("R10 unsupported opcode", {rd_o, ca_o, ca_we_o, cr0_o, cr0_we_o}, '0);
        end
        // R11: one cycle latency after reset release seen via a fresh op
        run(1, 8'h81, 1, 0, 1, 0, "R9 R11 right shift latency");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule